// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits between a memory controller's command scheduler and the column address pins of an SDRAM. Software or an init sequencer writes a 12-bit mode word into it with a load strobe. From that word the block takes the burst length, the wrap order, the full-page setting and the write override. It also decodes the CAS latency and passes that value on to the rest of the controller.

When a read or write starts, the block is given the starting column. From the next cycle on it produces one column address per clock for the whole burst. Each address comes with a valid strobe, a flag on the first beat and a flag on the final beat. A new start given on the final beat follows on with no idle cycle. Full-page bursts run until a stop input ends them, and the stop input ends any other active burst early as well.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: Reset is synchronous and active high. It clears col_valid, col_first and col_last and loads the default mode word 0x020 (one-beat bursts, sequential order, CAS latency 2). A mode_load high at a rising edge latches mode_word, and the new value takes effect from the next cycle.
- R2: Mode bits [2:0] give the burst length: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8. With bit 3 at 0 (sequential), beat k has address (start & ~(L-1)) | ((start + k) & (L-1)), so the burst wraps inside the aligned block of L columns.
- R3: With mode bit 3 at 1 (interleaved), beat k of a fixed-length burst has address start XOR k.
- R4: Code 111 in bits [2:0] selects full page. The address increments by one per beat and wraps from the top column of the row to 0. Bit 3 has no effect. The burst runs until stopped, and col_last is never raised in this mode.
- R5: When mode bit 9 is 1, a write (start_write=1) is a single beat whatever the length field says. Reads keep the programmed length, and with bit 9 at 0 writes use the programmed length too.
- R6: Codes 100, 101 and 110 in bits [2:0] raise mode_err, and the burst is treated as one beat long.
- R7: Mode bits [6:4] give cas_lat: 010 gives 2 and 011 gives 3. Any other code gives 0 and raises mode_err.
- R8: A start sampled at a rising edge while idle puts beat 0 (address = start_col) on the outputs in the next cycle with col_valid and col_first high. col_first is low on every later beat.
- R9: col_last is high on exactly the final beat of a fixed-length burst. After that beat col_valid falls, unless a start is sampled on the final beat. In that case the new burst's beat 0 follows in the very next cycle.
- R10: A start sampled while a burst is active, not on its final beat and without stop, is ignored. The running burst continues unchanged.
- R11: stop sampled high during an active burst makes col_valid low in the next cycle. If start is high at the same edge, the new burst begins instead.
- R12: A mode load during a burst does not change that burst. The new mode applies from the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Latch mode_word at this edge |
| mode_word | input | 12 | Mode word: length, order, CAS latency, write override |
| start | input | 1 | Begin a burst |
| start_col | input | COL_W | First column of the burst |
| start_write | input | 1 | 1 when the burst is a write |
| stop | input | 1 | End the active burst |
| col_addr | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | col_addr is a burst beat |
| col_first | output | 1 | Current beat is beat 0 |
| col_last | output | 1 | Current beat is the final one |
| cas_lat | output | 2 | Decoded CAS latency (0 if reserved) |
| mode_err | output | 1 | Latched mode word has a reserved field |

## Verification
Two functions can fall in the same cycle. One is the end of a burst, either through its final beat or through a stop. The other is the acceptance of a new start. The bench raises start exactly on the cycle where col_last is high. It also raises start together with stop in the middle of a full-page burst. In both cases the next cycle must show the new start column with col_first high and no idle gap. A start raised on an earlier beat must leave the running address sequence untouched.

// File: rtl/sdr_colgen_pkg.sv
package sdr_colgen_pkg;

    localparam int MODE_W = 12;

    // Decoded burst-related fields of the mode word
    typedef struct packed {
        logic [1:0] len_log;    // log2 of fixed burst length
        logic       page;       // full-page burst
        logic       ilv;        // interleaved order
        logic       wr_single;  // writes forced to one beat
        logic       bl_bad;     // reserved length code
    } burst_mode_t;

    function automatic burst_mode_t decode_burst(input logic [MODE_W-1:0] w);
        burst_mode_t m;
        m           = '0;
        m.ilv       = w[3];
        m.wr_single = w[9];
        case (w[2:0])
            3'b000:  m.len_log = 2'd0;
            3'b001:  m.len_log = 2'd1;
            3'b010:  m.len_log = 2'd2;
            3'b011:  m.len_log = 2'd3;
            3'b111:  m.page    = 1'b1;
            default: m.bl_bad  = 1'b1;
        endcase
        return m;
    endfunction

    function automatic logic [1:0] decode_cas(input logic [2:0] code);
        case (code)
            3'b010:  return 2'd2;
            3'b011:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/sdcg_mode_reg.sv
module sdcg_mode_reg
    import sdr_colgen_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_WORD = 12'h020
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output burst_mode_t       mode_o,
    output logic [1:0]        cas_o,
    output logic              err_o
);

    burst_mode_t mode_q;
    logic [1:0]  cas_q;
    logic        unused_bits;

    assign unused_bits = ^{word[11:10], word[8:7]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= decode_burst(RESET_WORD);
            cas_q  <= decode_cas(RESET_WORD[6:4]);
        end else if (load) begin
            mode_q <= decode_burst(word);
            cas_q  <= decode_cas(word[6:4]);
        end
    end

    assign mode_o = mode_q;
    assign cas_o  = cas_q;
    assign err_o  = mode_q.bl_bad | (cas_q == 2'd0);

endmodule

// File: rtl/sdcg_burst_ctl.sv
module sdcg_burst_ctl
    import sdr_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  burst_mode_t      mode_i,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_write,
    input  logic             stop,
    output logic             active_o,
    output logic             first_o,
    output logic             last_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [COL_W-1:0] mask_o,
    output logic             ilv_o
);

    logic             active_q, first_q, page_q, ilv_q;
    logic [COL_W-1:0] cnt_q, base_q, mask_q;
    logic [COL_W-1:0] new_mask;
    logic             new_ilv, at_last, take_new;

    // Length mask for the burst about to be accepted
    always_comb begin
        if (start_write && mode_i.wr_single)
            new_mask = '0;
        else if (mode_i.page)
            new_mask = '1;
        else
            new_mask = COL_W'((32'd1 << mode_i.len_log) - 32'd1);
        new_ilv = mode_i.ilv && !mode_i.page;
    end

    assign at_last  = active_q && !page_q && (cnt_q == mask_q);
    assign take_new = start && (!active_q || at_last || stop);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            first_q  <= 1'b0;
            page_q   <= 1'b0;
            ilv_q    <= 1'b0;
            cnt_q    <= '0;
            base_q   <= '0;
            mask_q   <= '0;
        end else if (take_new) begin
            active_q <= 1'b1;
            first_q  <= 1'b1;
            page_q   <= mode_i.page && !(start_write && mode_i.wr_single);
            ilv_q    <= new_ilv;
            cnt_q    <= '0;
            base_q   <= start_col;
            mask_q   <= new_mask;
        end else if (active_q) begin
            first_q <= 1'b0;
            if (stop || at_last)
                active_q <= 1'b0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign active_o = active_q;
    assign first_o  = first_q;
    assign last_o   = at_last;
    assign base_o   = base_q;
    assign cnt_o    = cnt_q;
    assign mask_o   = mask_q;
    assign ilv_o    = ilv_q;

endmodule

// File: rtl/sdcg_addr_calc.sv
module sdcg_addr_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] addr
);

    logic [COL_W-1:0] seq_sum;

    assign seq_sum = base + cnt;

    // Bits under the mask move with the beat index, the rest keep the start column
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!mask[i])
                addr[i] = base[i];
            else if (ilv)
                addr[i] = base[i] ^ cnt[i];
            else
                addr[i] = seq_sum[i];
        end
    end

endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen
    import sdr_colgen_pkg::*;
#(
    parameter int                COL_W      = 8,
    parameter logic [MODE_W-1:0] RESET_MODE = 12'h020
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_load,
    input  logic [11:0]      mode_word,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_write,
    input  logic             stop,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_first,
    output logic             col_last,
    output logic [1:0]       cas_lat,
    output logic             mode_err
);

    burst_mode_t      mode;
    logic [COL_W-1:0] base, cnt, mask;
    logic             ilv;

    sdcg_mode_reg #(.RESET_WORD(RESET_MODE)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .load   (mode_load),
        .word   (mode_word),
        .mode_o (mode),
        .cas_o  (cas_lat),
        .err_o  (mode_err)
    );

    sdcg_burst_ctl #(.COL_W(COL_W)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .start       (start),
        .start_col   (start_col),
        .start_write (start_write),
        .stop        (stop),
        .active_o    (col_valid),
        .first_o     (col_first),
        .last_o      (col_last),
        .base_o      (base),
        .cnt_o       (cnt),
        .mask_o      (mask),
        .ilv_o       (ilv)
    );

    sdcg_addr_calc #(.COL_W(COL_W)) u_calc (
        .base (base),
        .cnt  (cnt),
        .mask (mask),
        .ilv  (ilv),
        .addr (col_addr)
    );

endmodule

// File: rtl/sdram_col_burst_gen_chk.sv
module sdram_col_burst_gen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             stop,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             col_first,
    input logic             col_last,
    input logic [1:0]       cas_lat,
    input logic             mode_err
);

    a_r9_last_has_valid: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

    a_r8_idle_start: assert property (@(posedge clk) disable iff (rst)
        (!col_valid && start) |=> (col_valid && col_first && col_addr == $past(start_col)));

    a_r9_drop_after_last: assert property (@(posedge clk) disable iff (rst)
        (col_last && !start) |=> !col_valid);

    a_r11_stop_ends: assert property (@(posedge clk) disable iff (rst)
        (col_valid && stop && !start) |=> !col_valid);

    a_r8_beats_move: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !col_first) |-> ($past(col_valid) && col_addr != $past(col_addr)));

    a_r7_cas_legal: assert property (@(posedge clk) disable iff (rst)
        !mode_err |-> (cas_lat == 2'd2 || cas_lat == 2'd3));

endmodule

bind sdram_col_burst_gen sdram_col_burst_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_col (start_col),
    .stop      (stop),
    .col_addr  (col_addr),
    .col_valid (col_valid),
    .col_first (col_first),
    .col_last  (col_last),
    .cas_lat   (cas_lat),
    .mode_err  (mode_err)
);

// File: tb/sdram_col_burst_gen_bench.sv
`timescale 1ns/1ps
module sdram_col_burst_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_load = 1'b0;
    logic [11:0] mode_word = '0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic       start_write = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] col_addr;
    logic       col_valid, col_first, col_last, mode_err;
    logic [1:0] cas_lat;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sdram_col_burst_gen u_sdram_col_burst_gen (
        .clk(clk), .rst(rst), .mode_load(mode_load), .mode_word(mode_word),
        .start(start), .start_col(start_col), .start_write(start_write), .stop(stop),
        .col_addr(col_addr), .col_valid(col_valid), .col_first(col_first),
        .col_last(col_last), .cas_lat(cas_lat), .mode_err(mode_err)
    );

    // [91:80] mode, [79:72] col, [71] write, [70:67] beats, [66:3] addresses (beat 0 on top), [2] err, [1:0] cas
    localparam int NV = 11;
    localparam logic [91:0] VEC [NV] = '{
        {12'h022, 8'h15, 1'b0, 4'd4, 64'h15161714_00000000, 1'b0, 2'd2},
        {12'h02B, 8'h35, 1'b0, 4'd8, 64'h35343736_31303332, 1'b0, 2'd2},
        {12'h023, 8'h46, 1'b0, 4'd8, 64'h46474041_42434445, 1'b0, 2'd2},
        {12'h029, 8'h81, 1'b0, 4'd2, 64'h81800000_00000000, 1'b0, 2'd2},
        {12'h02A, 8'h0E, 1'b0, 4'd4, 64'h0E0F0C0D_00000000, 1'b0, 2'd2},
        {12'h223, 8'h46, 1'b1, 4'd1, 64'h46000000_00000000, 1'b0, 2'd2},
        {12'h223, 8'h46, 1'b0, 4'd8, 64'h46474041_42434445, 1'b0, 2'd2},
        {12'h020, 8'h7F, 1'b0, 4'd1, 64'h7F000000_00000000, 1'b0, 2'd2},
        {12'h024, 8'h9A, 1'b0, 4'd1, 64'h9A000000_00000000, 1'b1, 2'd2},
        {12'h031, 8'hFF, 1'b0, 4'd2, 64'hFFFE0000_00000000, 1'b0, 2'd3},
        {12'h031, 8'h10, 1'b1, 4'd2, 64'h10110000_00000000, 1'b0, 2'd3}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 2:    return "R2";
            1, 3, 4: return "R3";
            5, 6, 10: return "R5";
            7:       return "R1";
            8:       return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic beat(input string req, input logic [7:0] ea, input logic ef, input logic el);
        check(req, "valid", int'(col_valid), 1);
        check(req, "addr", int'(col_addr), int'(ea));
        check(req, "first", int'(col_first), int'(ef));
        check(req, "last", int'(col_last), int'(el));
    endtask

    task automatic load_mode(input logic [11:0] w);
        @(negedge clk);
        mode_load = 1'b1;
        mode_word = w;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    // Raise start at the current negedge; returns at the negedge where beat 0 shows
    task automatic go(input logic [7:0] c, input logic wr);
        start = 1'b1;
        start_col = c;
        start_write = wr;
        @(negedge clk);
        start = 1'b0;
        start_write = 1'b0;
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "reset valid", int'(col_valid), 0);
        check("R1", "reset first", int'(col_first), 0);
        check("R1", "reset last", int'(col_last), 0);
        check("R1", "reset cas", int'(cas_lat), 2);
        check("R1", "reset err", int'(mode_err), 0);

        // Table of modes and expected bursts
        for (int i = 0; i < NV; i++) begin
            int nb;
            nb = int'(VEC[i][70:67]);
            load_mode(VEC[i][91:80]);
            check(vec_tag(i), "err", int'(mode_err), int'(VEC[i][2]));
            check("R7", "cas", int'(cas_lat), int'(VEC[i][1:0]));
            go(VEC[i][79:72], VEC[i][71]);
            for (int k = 0; k < nb; k++) begin
                if (k > 0) @(negedge clk);
                beat(vec_tag(i), VEC[i][59-8*k +: 8], k == 0, k == nb - 1);
            end
            @(negedge clk);
            check("R9", "valid after burst", int'(col_valid), 0);
        end

        // R9: start on the final beat follows with no gap
        load_mode(12'h022);
        go(8'h15, 1'b0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R9", "last before chain", int'(col_last), 1);
        go(8'h20, 1'b0);
        beat("R9", 8'h20, 1'b1, 1'b0);
        @(negedge clk); beat("R9", 8'h21, 1'b0, 1'b0);
        @(negedge clk); beat("R9", 8'h22, 1'b0, 1'b0);
        @(negedge clk); beat("R9", 8'h23, 1'b0, 1'b1);
        @(negedge clk);
        check("R9", "valid after chain", int'(col_valid), 0);

        // R10: start in mid-burst is ignored
        go(8'h15, 1'b0);
        @(negedge clk);
        go(8'h50, 1'b0);
        beat("R10", 8'h17, 1'b0, 1'b0);
        @(negedge clk); beat("R10", 8'h14, 1'b0, 1'b1);
        @(negedge clk);
        check("R10", "valid after ignored start", int'(col_valid), 0);

        // R12: mode load mid-burst leaves the burst alone
        load_mode(12'h023);
        go(8'h46, 1'b0);
        beat("R12", 8'h46, 1'b1, 1'b0);
        mode_load = 1'b1;
        mode_word = 12'h020;
        @(negedge clk);
        mode_load = 1'b0;
        beat("R12", 8'h47, 1'b0, 1'b0);
        for (int k = 2; k < 8; k++) begin
            @(negedge clk);
            beat("R12", 8'h40 + 8'(k - 2), 1'b0, k == 7);
        end
        @(negedge clk);
        check("R12", "valid after burst", int'(col_valid), 0);
        go(8'h33, 1'b0);
        beat("R12", 8'h33, 1'b1, 1'b1);
        @(negedge clk);
        check("R12", "new mode one beat", int'(col_valid), 0);

        // R4: full page wraps at row end, runs until stop
        load_mode(12'h027);
        go(8'hFE, 1'b0);
        for (int k = 0; k < 260; k++) begin
            if (k > 0) @(negedge clk);
            beat("R4", 8'(8'hFE + k), k == 0, 1'b0);
        end
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R11", "valid after stop", int'(col_valid), 0);

        // R4: order bit has no effect in full page; R11: stop with start
        load_mode(12'h02F);
        go(8'h05, 1'b0);
        beat("R4", 8'h05, 1'b1, 1'b0);
        @(negedge clk); beat("R4", 8'h06, 1'b0, 1'b0);
        @(negedge clk); beat("R4", 8'h07, 1'b0, 1'b0);
        @(negedge clk); beat("R4", 8'h08, 1'b0, 1'b0);
        stop = 1'b1;
        go(8'h10, 1'b0);
        stop = 1'b0;
        beat("R11", 8'h10, 1'b1, 1'b0);
        @(negedge clk); beat("R11", 8'h11, 1'b0, 1'b0);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R11", "valid after second stop", int'(col_valid), 0);

        // R7: reserved and CAS 3 codes
        load_mode(12'h042);
        check("R7", "reserved cas", int'(cas_lat), 0);
        check("R7", "reserved cas err", int'(mode_err), 1);
        load_mode(12'h032);
        check("R7", "cas 3", int'(cas_lat), 3);
        check("R7", "cas 3 err", int'(mode_err), 0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule